// File: doc/BRIEF.md
# Peer Wake and Link Resynchronization Sequencer

This host-side controller brings a sleeping serial peer back into service and proves that the command channel works before the host uses it. It sits on top of a byte-wide UART transmit/receive interface. A wake request makes it transmit one all-ones byte. The low start bit of that byte is the wake pulse, and the peer does not read the byte as a command. The controller then stays quiet through a dead interval in which the peer would drop anything it receives.

When the dead interval ends, the controller transmits a probe command byte and waits for the peer to answer with the bitwise complement of the probe. A timed-out probe is sent again, and so is a probe that draws the wrong answer. A correct answer sets link-ready. A retry limit that runs out sets link-fail. Every interval is given in microseconds and converted to clock cycles from a clock-frequency parameter. A static check compares one bit time at the configured baud rate with the minimum wake-pulse width and reports a configuration error when the bit is too short.

Top module: `wake_resync_seq`

## Requirements
- R1: A wake request is taken only while the controller is idle, ready or failed and the configuration is valid. The first byte it then presents on the transmit side is 0xFF.
- R2: The probe byte is first presented exactly DEAD cycles after the clock edge that accepts the wake byte, where DEAD = ceil(CLK_HZ * DEAD_US / 1e6).
- R3: Every later byte of a session is the probe 0x0F. A presented byte keeps its value until the UART accepts it.
- R4: A byte received during the dead interval is dropped: even a correct reply value there neither sets link-ready nor ends the session.
- R5: A received byte equal to 0xF0 (the complement of the probe) while a reply is awaited raises link_ready and drops busy in the next cycle. link_ready then holds, with no transmission, until a new wake request.
- R6: With no reply, the probe is presented again exactly REPLY cycles after the edge that accepted the previous probe, where REPLY = ceil(CLK_HZ * REPLY_US / 1e6).
- R7: A received byte other than 0xF0 while a reply is awaited makes the probe present again in the next cycle.
- R8: After MAX_TRIES probes without a correct reply, link_fail rises when the last probe times out, and nothing more is transmitted.
- R9: A wake request while a session is running has no effect: the session continues with probes and sends no second 0xFF.
- R10: cfg_err is high when BAUD * WAKE_MIN_NS exceeds 1e9, meaning one bit is shorter than the minimum wake pulse. Such an instance ignores wake requests and never transmits.
- R11: After reset the controller is idle with tx_valid, busy, link_ready and link_fail low. busy is high from an accepted wake request until link_ready or link_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_req | input | 1 | Request to wake the peer and resynchronize |
| tx_valid | output | 1 | Byte presented to the UART transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART transmitter accepts the presented byte this cycle |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_data | input | 8 | Received byte |
| link_ready | output | 1 | Peer answered the probe correctly |
| link_fail | output | 1 | Retry limit exhausted without a correct answer |
| busy | output | 1 | Wake/probe session in progress |
| cfg_err | output | 1 | Baud rate too high for a valid wake pulse |

## Verification
Each result is due a fixed number of clock edges after its cause. A received byte changes link_ready or busy one edge later. A wrong reply brings the probe back one edge later. The first probe is due DEAD edges after the wake byte is accepted, and a silent probe is repeated REPLY edges after it was accepted. link_fail is due REPLY edges after the last probe is accepted. The bench counts every rising edge and notes the edge at which each handshake happens. It samples on falling edges and compares the cycle at which tx_valid first goes high, or a flag first rises, against these counts exactly, so a result that comes one cycle early or one cycle late fails the check.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_WAKE,
    ST_WAKE_WAIT,
    ST_SEND_PROBE,
    ST_WAIT_REPLY,
    ST_READY,
    ST_FAIL
  } wrs_state_e;

  localparam logic [7:0] WAKE_BYTE = 8'hFF;

  // Microseconds to clock cycles, rounded up, never below one cycle.
  function automatic longint unsigned us_to_cycles(input longint unsigned hz,
                                                   input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/wrs_timer.sv
module wrs_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          zero
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/wrs_retry.sv
module wrs_retry #(
  parameter int unsigned MAX_TRIES = 16,
  localparam int unsigned CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  logic [CW-1:0] tries_q;
  logic [CW-1:0] tries_d;
  logic          tries_en;

  always_comb begin
    tries_en = 1'b0;
    tries_d  = tries_q;
    if (clr) begin
      tries_en = 1'b1;
      tries_d  = '0;
    end else if (inc && !last) begin
      tries_en = 1'b1;
      tries_d  = tries_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (tries_en) begin
      tries_q <= tries_d;
    end
  end

  assign last = (tries_q >= CW'(MAX_TRIES));

endmodule

// File: rtl/wrs_reply_match.sv
module wrs_reply_match #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] PROBE_BYTE = 8'h0F
) (
  input  logic          enable,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          hit,
  output logic          miss
);

  logic [DW-1:0] bit_ok;

  // Each received bit must be the inverse of the matching probe bit.
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign bit_ok[b] = rx_data[b] ^ PROBE_BYTE[b];
  end

  assign hit  = enable && rx_valid && (&bit_ok);
  assign miss = enable && rx_valid && !(&bit_ok);

endmodule

// File: rtl/wake_resync_seq.sv
module wake_resync_seq
  import wrs_pkg::*;
#(
  parameter int unsigned   CLK_HZ      = 100_000_000,
  parameter int unsigned   BAUD        = 115_200,
  parameter int unsigned   WAKE_MIN_NS = 8_500,
  parameter int unsigned   DEAD_US     = 1_500,
  parameter int unsigned   REPLY_US    = 2_000,
  parameter int unsigned   MAX_TRIES   = 16,
  parameter logic [7:0]    PROBE_BYTE  = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_req,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       link_ready,
  output logic       link_fail,
  output logic       busy,
  output logic       cfg_err
);

  localparam int unsigned DEAD_CYC  = 32'(us_to_cycles(64'(CLK_HZ), 64'(DEAD_US)));
  localparam int unsigned REPLY_CYC = 32'(us_to_cycles(64'(CLK_HZ), 64'(REPLY_US)));
  localparam int unsigned MAX_CYC   = (DEAD_CYC > REPLY_CYC) ? DEAD_CYC : REPLY_CYC;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);
  localparam bit          CFG_BAD   =
    (64'(BAUD) * 64'(WAKE_MIN_NS)) > 64'd1_000_000_000;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_i = rst_pipe_q[1];

  wrs_state_e state_q;
  wrs_state_e state_d;
  logic       state_en;

  logic       at_rest;
  logic       wake_take;
  logic       wake_fire;
  logic       probe_fire;
  logic       tmr_load;
  logic [TW-1:0] tmr_val;
  logic       tmr_run;
  logic       tmr_zero;
  logic       try_last;
  logic       reply_hit;
  logic       reply_miss;

  assign at_rest    = (state_q == ST_IDLE) || (state_q == ST_READY) ||
                      (state_q == ST_FAIL);
  assign wake_take  = at_rest && wake_req && !CFG_BAD;
  assign wake_fire  = (state_q == ST_SEND_WAKE) && tx_ready;
  assign probe_fire = (state_q == ST_SEND_PROBE) && tx_ready;

  assign tmr_load = wake_fire || probe_fire;
  assign tmr_val  = wake_fire ? TW'(DEAD_CYC - 1) : TW'(REPLY_CYC - 1);
  assign tmr_run  = (state_q == ST_WAKE_WAIT) || (state_q == ST_WAIT_REPLY);

  wrs_timer #(
    .TW(TW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .zero     (tmr_zero)
  );

  wrs_retry #(
    .MAX_TRIES(MAX_TRIES)
  ) u_retry (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (wake_take),
    .inc   (probe_fire),
    .last  (try_last)
  );

  // Only compared while a reply is awaited; dead-interval bytes are dropped.
  wrs_reply_match #(
    .DW         (8),
    .PROBE_BYTE (PROBE_BYTE)
  ) u_match (
    .enable   (state_q == ST_WAIT_REPLY),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .hit      (reply_hit),
    .miss     (reply_miss)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_READY, ST_FAIL: begin
        if (wake_take) state_d = ST_SEND_WAKE;
      end
      ST_SEND_WAKE: begin
        if (tx_ready) state_d = ST_WAKE_WAIT;
      end
      ST_WAKE_WAIT: begin
        if (tmr_zero) state_d = ST_SEND_PROBE;
      end
      ST_SEND_PROBE: begin
        if (tx_ready) state_d = ST_WAIT_REPLY;
      end
      ST_WAIT_REPLY: begin
        if (reply_hit) begin
          state_d = ST_READY;
        end else if (reply_miss || tmr_zero) begin
          state_d = try_last ? ST_FAIL : ST_SEND_PROBE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign tx_valid   = (state_q == ST_SEND_WAKE) || (state_q == ST_SEND_PROBE);
  assign tx_data    = (state_q == ST_SEND_WAKE) ? WAKE_BYTE : PROBE_BYTE;
  assign link_ready = (state_q == ST_READY);
  assign link_fail  = (state_q == ST_FAIL);
  assign busy       = !at_rest;
  assign cfg_err    = CFG_BAD;

endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
  parameter int unsigned MAX_TRIES  = 16,
  parameter logic [7:0]  PROBE_BYTE = 8'h0F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_req,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       link_ready,
  input logic       link_fail,
  input logic       busy,
  input logic       cfg_err
);

  // Probes accepted since the last wake byte, counted independently.
  logic [15:0] probe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_cnt <= '0;
    end else if (tx_valid && tx_ready && (tx_data == 8'hFF)) begin
      probe_cnt <= '0;
    end else if (tx_valid && tx_ready && (tx_data == PROBE_BYTE) &&
                 (probe_cnt != 16'hFFFF)) begin
      probe_cnt <= probe_cnt + 16'd1;
    end
  end

  p_wake_byte_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tx_valid && (tx_data == 8'hFF)));

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_ready_needs_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(rx_valid && (rx_data == ~PROBE_BYTE)));

  p_ready_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && !wake_req) |=> (link_ready && !tx_valid));

  p_probe_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    probe_cnt <= 16'(MAX_TRIES));

  p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> !tx_valid);

  p_cfg_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !tx_valid));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_ready && link_fail) && !(busy && (link_ready || link_fail)));

endmodule

bind wake_resync_seq wrs_checker #(
  .MAX_TRIES  (MAX_TRIES),
  .PROBE_BYTE (PROBE_BYTE)
) u_wrs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wake_req   (wake_req),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_data    (rx_data),
  .link_ready (link_ready),
  .link_fail  (link_fail),
  .busy       (busy),
  .cfg_err    (cfg_err)
);

// File: tb/wake_resync_seq_tb.sv
module wake_resync_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 1_000_000;
  localparam int DEAD_US    = 1_500;
  localparam int REPLY_US   = 200;
  localparam int MAXT       = 5;
  localparam int GOOD_BAUD  = 115_200;
  localparam int BAD_BAUD   = 230_400;
  localparam logic [7:0] PROBE = 8'h0F;
  localparam logic [7:0] ANSWER = 8'hF0;

  function automatic int exp_cycles(input longint hz, input longint us);
    longint c;
    c = (hz * us + 999_999) / 1_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic bit exp_cfg_bad(input longint baud);
    return (baud * 8_500) > 64'd1_000_000_000;
  endfunction

  localparam int DEAD_CYC  = exp_cycles(HZ, DEAD_US);
  localparam int REPLY_CYC = exp_cycles(HZ, REPLY_US);

  logic       clk;
  logic       rst_n;
  logic       wake_req;
  logic       tx_ready;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tx_valid, link_ready, link_fail, busy, cfg_err;
  logic [7:0] tx_data;
  logic       b_tx_valid, b_link_ready, b_link_fail, b_busy, b_cfg_err;
  logic [7:0] b_tx_data;

  int  cyc;
  int  n_chk;
  int  n_err;
  bit  rnd_ready;
  bit  bad_seen;

  wake_resync_seq #(
    .CLK_HZ(HZ), .BAUD(GOOD_BAUD), .WAKE_MIN_NS(8_500), .DEAD_US(DEAD_US),
    .REPLY_US(REPLY_US), .MAX_TRIES(MAXT), .PROBE_BYTE(PROBE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .link_ready(link_ready), .link_fail(link_fail),
    .busy(busy), .cfg_err(cfg_err)
  );

  wake_resync_seq #(
    .CLK_HZ(HZ), .BAUD(BAD_BAUD), .WAKE_MIN_NS(8_500), .DEAD_US(DEAD_US),
    .REPLY_US(REPLY_US), .MAX_TRIES(MAXT), .PROBE_BYTE(PROBE)
  ) u_bad (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .tx_valid(b_tx_valid),
    .tx_data(b_tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .link_ready(b_link_ready), .link_fail(b_link_fail),
    .busy(b_busy), .cfg_err(b_cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && (b_busy || b_tx_valid || b_link_ready || b_link_fail))
      bad_seen = 1'b1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Call at a falling edge; returns at the falling edge after the handshake.
  task automatic wait_tx(output logic [7:0] d, output int fs, output int hs);
    bit done;
    done = 1'b0;
    fs   = -1;
    while (!done) begin
      if (tx_valid && fs < 0) fs = cyc;
      tx_ready = rnd_ready ? ($urandom_range(3, 0) != 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        d    = tx_data;
        hs   = cyc + 1;
        done = 1'b1;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
  endtask

  task automatic run_session(input int good_at, input bit drop_test,
                             input bit wake_in_wait);
    logic [7:0] d;
    logic [7:0] w;
    int fs, hs, hs_w, exp_fs, c, dly;
    bit ok;
    string tag;
    pulse_wake();
    chk(busy == 1'b1, "R11", "busy after wake request", busy, 1);
    wait_tx(d, fs, hs_w);
    chk(d == 8'hFF, "R1", "first byte after wake", d, 8'hFF);
    if (drop_test) begin
      repeat (4) @(negedge clk);
      rx_data  = ANSWER;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
      chk(!link_ready && busy, "R4", "answer in dead interval dropped",
          link_ready, 0);
    end
    exp_fs = hs_w + DEAD_CYC;
    tag    = "R2";
    for (int i = 1; i <= MAXT; i++) begin
      wait_tx(d, fs, hs);
      chk(d == PROBE, "R3", "probe byte value", d, PROBE);
      chk(fs == exp_fs, tag, "probe presentation cycle", fs, exp_fs);
      if (tag == "R9")
        chk(d != 8'hFF, "R9", "no second wake byte", d, PROBE);
      if (i == good_at) begin
        dly = $urandom_range(REPLY_CYC - 5, 0);
        repeat (dly) @(negedge clk);
        rx_data  = ANSWER;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(link_ready && !busy && !link_fail, "R5", "ready after answer",
            link_ready, 1);
        ok = 1'b1;
        repeat (12) begin
          @(negedge clk);
          if (!link_ready || tx_valid) ok = 1'b0;
        end
        chk(ok, "R5", "ready holds, no transmission", ok, 1);
        return;
      end else if (i == MAXT) begin
        while (!link_fail && cyc < hs + REPLY_CYC + 5) @(negedge clk);
        chk(link_fail && cyc == hs + REPLY_CYC, "R8", "fail cycle", cyc,
            hs + REPLY_CYC);
        ok = 1'b1;
        repeat (REPLY_CYC + 20) begin
          @(negedge clk);
          if (tx_valid || !link_fail) ok = 1'b0;
        end
        chk(ok, "R8", "quiet after fail", ok, 1);
        return;
      end else if (!wake_in_wait && $urandom_range(1, 0) == 1) begin
        dly = $urandom_range(REPLY_CYC - 5, 0);
        repeat (dly) @(negedge clk);
        do w = 8'($urandom()); while (w == ANSWER);
        c        = cyc;
        rx_data  = w;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        exp_fs = c + 1;
        tag    = "R7";
      end else begin
        exp_fs = hs + REPLY_CYC;
        tag    = "R6";
        if (wake_in_wait) begin
          @(negedge clk);
          pulse_wake();
          chk(busy && !link_ready, "R9", "wake while busy ignored", busy, 1);
          tag = "R9";
        end
      end
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog: actual=%0d expected=%0d", 200_000, 0);
    report();
  end

  initial begin
    int g;
    void'($urandom(32'd4242));
    cyc = 0; n_chk = 0; n_err = 0; bad_seen = 1'b0; rnd_ready = 1'b0;
    rst_n = 1'b0; wake_req = 1'b0; tx_ready = 1'b0;
    rx_valid = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !busy && !link_ready && !link_fail, "R11",
        "reset state", {tx_valid, busy, link_ready, link_fail}, 0);
    chk(cfg_err == exp_cfg_bad(GOOD_BAUD), "R10", "cfg_err at valid baud",
        cfg_err, exp_cfg_bad(GOOD_BAUD));
    chk(b_cfg_err == exp_cfg_bad(BAD_BAUD), "R10", "cfg_err at fast baud",
        b_cfg_err, exp_cfg_bad(BAD_BAUD));

    run_session(1, 1'b1, 1'b0);          // first probe answered, dead drop
    run_session(MAXT, 1'b0, 1'b0);       // answer on last allowed probe
    run_session(MAXT + 1, 1'b0, 1'b1);   // no answer, wake while busy
    run_session(2, 1'b0, 1'b0);          // rewake from the failed state
    rnd_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      g = $urandom_range(MAXT + 1, 1);
      run_session(g, 1'($urandom_range(1, 0)), 1'b0);
    end
    chk(!bad_seen, "R10", "misconfigured instance stays silent", bad_seen, 0);
    report();
  end

endmodule